// File: doc/BRIEF.md
# ECC Error Logging Status Register

This block gathers error events from an ECC-protected DRAM controller and keeps them in one status word for software. The ECC decoder reports each check it makes on a word read from memory. A check can come from a refresh scrub pass or from a bus access. Each report carries a single-bit (correctable) flag, a double-bit (uncorrectable) flag and the two syndrome groups the decoder computed. Separately, the parity checker on the write path reports whether each write into the module had good parity.

The block keeps four things. The first is a saturating count of correctable errors. The second is the syndromes of the latest check, which freeze at the first correctable error so software can find the failing device. The third is a capture enable that a status read re-arms. The fourth is a sticky parity-failure flag. Software reads the packed word on `csr_rdata`, pulses `csr_rd` to acknowledge the read, and writes clear bits through `csr_wr`/`csr_wdata`.

`csr_rdata` is a registered copy of the internal state. A change to the state shows on `csr_rdata` one clock after the state register updates.

Top module: `ecc_err_log`

## Requirements
- R1: A synchronous active-high `rst` clears the counter, both syndrome fields and the parity flag, and arms syndrome capture. `csr_rdata` reads zero after reset.
- R2: The error count sits in `csr_rdata[7:0]`. It increments by one for each check with `chk_sbe`=1, whether `chk_src` is 0 (bus access) or 1 (refresh).
- R3: A check with only `chk_dbe`=1 leaves the counter unchanged.
- R4: A CSR write with `csr_wdata[0]`=1 clears the counter. A CSR write with that bit at 0 leaves the counter alone.
- R5: The counter stops at 255. Further single-bit errors do not wrap it.
- R6: When a counter clear and a single-bit error arrive in the same cycle, the counter ends at 0.
- R7: While capture is armed, each valid check loads `chk_syn[6:0]` into `csr_rdata[14:8]` and `chk_syn[13:7]` into `csr_rdata[21:15]`.
- R8: A single-bit error that is captured disarms capture. Later checks, including double-bit errors, leave both syndrome fields unchanged.
- R9: A `csr_rd` pulse re-arms capture, so the next valid check loads new syndromes.
- R10: If `csr_rd` comes in the same cycle as a single-bit error being captured, capture stays disarmed.
- R11: A write with `wr_valid`=1 and `wr_par_ok`=0 sets the parity flag in `csr_rdata[22]`. The flag then stays set, whatever later writes do.
- R12: A CSR write with `csr_wdata[1]`=1 clears the parity flag.
- R13: If a parity failure and a parity clear arrive in the same cycle, the flag ends set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| chk_valid | input | 1 | An ECC check result is present this cycle |
| chk_src | input | 1 | Source of the check: 0 bus access, 1 refresh |
| chk_sbe | input | 1 | Correctable single-bit error flag |
| chk_dbe | input | 1 | Uncorrectable double-bit error flag |
| chk_syn | input | 14 | Two 7-bit syndrome groups of the check |
| wr_valid | input | 1 | A write into the module is being checked for parity |
| wr_par_ok | input | 1 | Parity check result of that write, 1 = good |
| csr_rd | input | 1 | Status word read strobe, re-arms capture |
| csr_wr | input | 1 | Status word write strobe |
| csr_wdata | input | 2 | Bit 0 clears counter, bit 1 clears parity flag |
| csr_rdata | output | 23 | Packed status: {parity, syndrome B, syndrome A, count} |

## Verification
The hardest states to reach from the ports are saturation and the same-cycle collisions. Saturation needs more than 255 correctable errors in a row. The stimulus clears the counter, then drives a long burst of single-bit errors that alternate between refresh and bus sources, and checks that the count stays at 255. The collisions are clear against increment, read against a freezing error, and parity clear against parity failure. Each is driven as one cycle with both inputs active, right after a setup sequence leaves the state where the two outcomes would differ. A scoreboard model predicts the packed word two clocks after each stimulus cycle.

// File: rtl/ecc_log_pkg.sv
package ecc_log_pkg;
  localparam int CNT_W   = 8;
  localparam int SYN_W   = 7;
  localparam int NUM_SYN = 2;
  localparam int CLR_CNT_BIT = 0;
  localparam int CLR_PAR_BIT = 1;
  localparam int CTRL_W      = 2;

  typedef enum logic {
    SRC_BUS     = 1'b0,
    SRC_REFRESH = 1'b1
  } chk_src_e;
endpackage

// File: rtl/ecc_err_counter.sv
module ecc_err_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  input  logic             clr,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk) begin
    if (rst)                          count <= '0;
    else if (clr)                     count <= '0;
    else if (inc && count != CNT_MAX) count <= count + 1'b1;
  end

  a_r6_clear_wins: assert property (@(posedge clk) disable iff (rst)
    clr |=> count == '0);
  a_r5_no_wrap: assert property (@(posedge clk) disable iff (rst)
    (count == CNT_MAX && !clr) |=> count == CNT_MAX);
  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    (!inc && !clr) |=> $stable(count));
  a_r2_step: assert property (@(posedge clk) disable iff (rst)
    (inc && !clr && count != CNT_MAX) |=> count == CNT_W'($past(count) + 1'b1));
endmodule

// File: rtl/ecc_syn_capture.sv
module ecc_syn_capture #(
  parameter int SYN_W   = 7,
  parameter int NUM_SYN = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     chk_valid,
  input  logic                     chk_sbe,
  input  logic [NUM_SYN*SYN_W-1:0] syn_in,
  input  logic                     rearm,
  output logic [NUM_SYN*SYN_W-1:0] syn_out
);
  logic armed_q;
  logic load;
  logic freeze;

  assign load   = chk_valid && armed_q;
  assign freeze = load && chk_sbe;

  always_ff @(posedge clk) begin
    if (rst)         armed_q <= 1'b1;
    else if (freeze) armed_q <= 1'b0;
    else if (rearm)  armed_q <= 1'b1;
  end

  for (genvar g = 0; g < NUM_SYN; g++) begin : g_field
    always_ff @(posedge clk) begin
      if (rst)       syn_out[g*SYN_W +: SYN_W] <= '0;
      else if (load) syn_out[g*SYN_W +: SYN_W] <= syn_in[g*SYN_W +: SYN_W];
    end
  end

  a_r7_capture: assert property (@(posedge clk) disable iff (rst)
    (chk_valid && armed_q) |=> syn_out == $past(syn_in));
  a_r8_frozen: assert property (@(posedge clk) disable iff (rst)
    !armed_q |=> $stable(syn_out));
  a_r8_disarm: assert property (@(posedge clk) disable iff (rst)
    (chk_valid && chk_sbe && armed_q) |=> !armed_q);
  a_r9_rearm: assert property (@(posedge clk) disable iff (rst)
    (rearm && !(chk_valid && chk_sbe && armed_q)) |=> armed_q);
endmodule

// File: rtl/ecc_par_flag.sv
module ecc_par_flag (
  input  logic clk,
  input  logic rst,
  input  logic wr_valid,
  input  logic wr_par_ok,
  input  logic clr,
  output logic flag
);
  logic set;
  assign set = wr_valid && !wr_par_ok;

  always_ff @(posedge clk) begin
    if (rst)      flag <= 1'b0;
    else if (set) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end

  a_r11_sticky: assert property (@(posedge clk) disable iff (rst)
    (flag && !clr) |=> flag);
  a_r13_set_wins: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && !wr_par_ok) |=> flag);
  a_r12_clear: assert property (@(posedge clk) disable iff (rst)
    (clr && !(wr_valid && !wr_par_ok)) |=> !flag);
endmodule

// File: rtl/ecc_err_log.sv
module ecc_err_log
  import ecc_log_pkg::*;
#(
  parameter int P_CNT_W   = CNT_W,
  parameter int P_SYN_W   = SYN_W,
  parameter int P_NUM_SYN = NUM_SYN,
  localparam int SYN_ALL  = P_NUM_SYN * P_SYN_W,
  localparam int RD_W     = P_CNT_W + SYN_ALL + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               chk_valid,
  input  logic               chk_src,
  input  logic               chk_sbe,
  input  logic               chk_dbe,
  input  logic [SYN_ALL-1:0] chk_syn,
  input  logic               wr_valid,
  input  logic               wr_par_ok,
  input  logic               csr_rd,
  input  logic               csr_wr,
  input  logic [CTRL_W-1:0]  csr_wdata,
  output logic [RD_W-1:0]    csr_rdata
);
  logic [P_CNT_W-1:0] cnt;
  logic [SYN_ALL-1:0] syn;
  logic               par;
  logic               sbe_evt;
  logic               clr_cnt;
  logic               clr_par;
  logic               unused_in;

  assign sbe_evt   = chk_valid && chk_sbe;
  assign clr_cnt   = csr_wr && csr_wdata[CLR_CNT_BIT];
  assign clr_par   = csr_wr && csr_wdata[CLR_PAR_BIT];
  assign unused_in = chk_src ^ chk_dbe;

  ecc_err_counter #(.CNT_W(P_CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .inc(sbe_evt), .clr(clr_cnt), .count(cnt)
  );

  ecc_syn_capture #(.SYN_W(P_SYN_W), .NUM_SYN(P_NUM_SYN)) u_syn (
    .clk(clk), .rst(rst), .chk_valid(chk_valid), .chk_sbe(chk_sbe),
    .syn_in(chk_syn), .rearm(csr_rd), .syn_out(syn)
  );

  ecc_par_flag u_par (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_par_ok(wr_par_ok),
    .clr(clr_par), .flag(par)
  );

  always_ff @(posedge clk) begin
    if (rst) csr_rdata <= '0;
    else     csr_rdata <= {par, syn, cnt};
  end

  a_r3_dbe_only: assert property (@(posedge clk) disable iff (rst)
    (chk_valid && chk_dbe && !chk_sbe && !clr_cnt) |=> $stable(cnt));
  a_r1_reset_zero: assert property (@(posedge clk)
    $past(rst) |-> csr_rdata == '0);
endmodule

// File: tb/sim_ecc_err_log.sv
module sim_ecc_err_log;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        chk_valid = 0, chk_src = 0, chk_sbe = 0, chk_dbe = 0;
  logic [13:0] chk_syn = '0;
  logic        wr_valid = 0, wr_par_ok = 1, csr_rd = 0, csr_wr = 0;
  logic [1:0]  csr_wdata = '0;
  logic [22:0] csr_rdata;

  int total = 0, bad = 0, cyc = 0;
  bit done = 0;

  typedef struct { logic [22:0] exp; int due; string tag; } item_t;
  item_t q[$];

  logic [7:0]  m_cnt = 0;
  logic [13:0] m_syn = 0;
  logic        m_arm = 1, m_par = 0;

  ecc_err_log u0 (.*);

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic idle();
    chk_valid = 0; chk_src = 0; chk_sbe = 0; chk_dbe = 0; chk_syn = '0;
    wr_valid = 0; wr_par_ok = 1; csr_rd = 0; csr_wr = 0; csr_wdata = '0;
  endtask

  task automatic tick(input string tag);
    item_t it;
    logic do_load;
    do_load = chk_valid && m_arm;
    if (csr_wr && csr_wdata[0])             m_cnt = 0;
    else if (chk_valid && chk_sbe && m_cnt != 8'hFF) m_cnt = m_cnt + 1;
    if (do_load) m_syn = chk_syn;
    if (do_load && chk_sbe) m_arm = 0;
    else if (csr_rd)        m_arm = 1;
    if (wr_valid && !wr_par_ok)       m_par = 1;
    else if (csr_wr && csr_wdata[1])  m_par = 0;
    it.exp = {m_par, m_syn, m_cnt};
    it.due = cyc + 2;
    it.tag = tag;
    q.push_back(it);
    @(negedge clk);
    idle();
  endtask

  always @(negedge clk) begin
    #1;
    if (q.size() > 0 && q[0].due == cyc) begin
      item_t it;
      it = q.pop_front();
      total++;
      if (csr_rdata !== it.exp) begin
        bad++;
        $display("FAIL %s actual=%h expected=%h", it.tag, csr_rdata, it.exp);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    total++;
    if (csr_rdata !== '0) begin
      bad++;
      $display("FAIL R1 actual=%h expected=0", csr_rdata);
    end
    tick("R1");
    // R2: single-bit errors from bus and refresh; R7 capture while armed
    chk_valid = 1; chk_syn = 14'h0155; tick("R7");
    chk_valid = 1; chk_sbe = 1; chk_src = 0; chk_syn = 14'h2A0F; tick("R2");
    // R8: frozen now
    chk_valid = 1; chk_sbe = 1; chk_src = 1; chk_syn = 14'h1111; tick("R8");
    chk_valid = 1; chk_dbe = 1; chk_syn = 14'h3333; tick("R3");
    chk_valid = 1; chk_syn = 14'h0777; tick("R8");
    // R9: re-arm by read
    csr_rd = 1; tick("R9");
    chk_valid = 1; chk_syn = 14'h1234; tick("R9");
    chk_valid = 1; chk_dbe = 1; chk_syn = 14'h0ABC; tick("R3");
    // R10: read with freezing error same cycle
    chk_valid = 1; chk_sbe = 1; chk_syn = 14'h2222; csr_rd = 1; tick("R10");
    chk_valid = 1; chk_syn = 14'h0001; tick("R10");
    // R4: write with clear bit 0 low does not clear count
    csr_wr = 1; csr_wdata = 2'b10; tick("R4");
    csr_wr = 1; csr_wdata = 2'b01; tick("R4");
    // R6: clear vs increment
    chk_valid = 1; chk_sbe = 1; chk_src = 1; tick("R2");
    chk_valid = 1; chk_sbe = 1; csr_wr = 1; csr_wdata = 2'b01; tick("R6");
    // R5: saturation
    for (int k = 0; k < 262; k++) begin
      csr_rd = 1; chk_valid = 1; chk_sbe = 1; chk_src = k[0];
      chk_syn = 14'(k * 37);
      tick("R5");
    end
    tick("R5");
    // R11..R13 parity
    wr_valid = 1; wr_par_ok = 1; tick("R11");
    wr_valid = 1; wr_par_ok = 0; tick("R11");
    wr_valid = 1; wr_par_ok = 1; tick("R11");
    csr_wr = 1; csr_wdata = 2'b01; tick("R11");
    csr_wr = 1; csr_wdata = 2'b10; tick("R12");
    wr_valid = 1; wr_par_ok = 0; csr_wr = 1; csr_wdata = 2'b10; tick("R13");
    tick("R13");
    csr_wr = 1; csr_wdata = 2'b11; tick("R12");
    repeat (4) tick("R1");
    while (q.size() > 0) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule